// File: doc/BRIEF.md
# Product-Term Steering and Sharing Block

This block sits between the AND plane of a programmable logic block and its sixteen macrocells. It takes 80 general product-term results and forms one sum-of-products value for each macrocell. Each macrocell holds a 16-bit selection mask, and each mask bit picks one candidate term from a fixed window. Macrocells are grouped in fours, and within a group their windows overlap. A term that several neighbours need is therefore computed once in the AND plane and used by all of them.

Six further dedicated terms are passed through the block. Four of them are output-enable terms. The upper eight macrocells choose between enable terms 0 and 1, and the lower eight choose between terms 2 and 3, with one select bit per macrocell. The last two terms drive the block-wide asynchronous preset and clear.

Configuration is loaded one macrocell per clock through a small write port and is expected to stay still during normal operation. The sum path is purely combinational. It has the same depth, a 16-input AND-OR, whatever the masks hold.

Top module: `ptalloc_block`

## Requirements
- R1: A synchronous active-low reset clears every mask and every OE select. After reset every `mc_sum` bit is 0 for any term values, and each macrocell's enable follows the first term of its pair.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_mask` and `cfg_oe_sel` are stored for macrocell `cfg_addr`. The new setting governs the outputs from just after that edge.
- R3: While `cfg_we` is low, changes on `cfg_addr`, `cfg_mask` and `cfg_oe_sel` have no effect on any output across clock edges.
- R4: A macrocell whose mask is all zero drives a constant 0 on `mc_sum`, even when every general term is 1.
- R5: Macrocell m belongs to group g = m/4 with local position j = m%4. Its window starts at term g*20 + (j*4)/3, which gives offsets 0, 1, 2 and 4. Mask bit b selects term start+b, and `mc_sum[m]` is the OR of the selected terms.
- R6: One general term can feed every macrocell of its group whose window covers it. With only that term high, all such macrocells with the matching mask bit set show 1 and all other macrocells show 0.
- R7: For macrocells 0 to 7, `mc_oe` follows `oe_pt[0]` when the select is 0 and `oe_pt[1]` when it is 1. For macrocells 8 to 15 it follows `oe_pt[2]` or `oe_pt[3]` in the same way. A half never reacts to the other half's pair.
- R8: `blk_preset` equals `sr_pt[0]` and `blk_clear` equals `sr_pt[1]` at all times, with no configuration involved.
- R9: `mc_sum` and `mc_oe` respond to changes on the term inputs in the same cycle, with no clock edge needed.
- R10: With a full mask and all general terms at 1, a macrocell's sum is 1, and any number of selected terms from 0 to 16 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Macrocell index to write |
| cfg_mask | input | 16 | Term selection mask for the addressed macrocell |
| cfg_oe_sel | input | 1 | Picks the second enable term of the half's pair |
| gp_pt | input | 80 | General product-term values |
| oe_pt | input | 4 | Output-enable product terms (0,1 upper; 2,3 lower) |
| sr_pt | input | 2 | Bit 0 preset term, bit 1 clear term |
| mc_sum | output | 16 | Sum-of-products value per macrocell |
| mc_oe | output | 16 | Output enable per macrocell |
| blk_preset | output | 1 | Block asynchronous preset |
| blk_clear | output | 1 | Block asynchronous clear |

## Verification
A wrong stored mask shows on `mc_sum` as soon as one of the affected window terms is driven alone. Sparse random term patterns make a missing or extra selected term visible within a few patterns. A write that lands on the wrong macrocell, or a window off by one position, changes the sum in the same cycle as the next term pattern, and the bench compares every macrocell after every pattern. A flipped or crossed enable select shows immediately when the two terms of a pair are driven to different values.

// File: rtl/ptalloc_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the product-term steering block.
// Assumes macrocells are grouped evenly and each group owns an equal term slice.
package ptalloc_pkg;

    // Window start for a macrocell: group base plus a spread offset so the
    // last macrocell of a group reaches the last term of the group's slice.
    function automatic int win_base(input int mc, input int grp, input int tpg, input int win);
        int g;
        int j;
        g = mc / grp;
        j = mc % grp;
        return g * tpg + (j * (tpg - win)) / (grp - 1);
    endfunction

endpackage

// File: rtl/ptalloc_cfg.sv
`timescale 1ns/1ps
// Module: ptalloc_cfg
// Holds one term mask and one enable select per macrocell.
// Written one entry per clock; assumed static while the logic is in use.
module ptalloc_cfg #(
    parameter int N_MC = 16,
    parameter int WIN  = 16,
    localparam int AW  = $clog2(N_MC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             addr,
    input  logic [WIN-1:0]            mask_in,
    input  logic                      sel_in,
    output logic [N_MC-1:0][WIN-1:0]  mask_q,
    output logic [N_MC-1:0]           sel_q
);

    // Store the addressed entry on a write; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            sel_q  <= '0;
        end else if (we) begin
            mask_q[addr] <= mask_in;
            sel_q[addr]  <= sel_in;
        end
    end

    // R2: a write lands in the addressed entry
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mask_q[$past(addr)] == $past(mask_in)) && (sel_q[$past(addr)] == $past(sel_in)));

    // R3: without a write strobe the store does not move
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mask_q) && $stable(sel_q));

endmodule

// File: rtl/ptalloc_sum.sv
`timescale 1ns/1ps
// Module: ptalloc_sum
// One macrocell OR gate over a window of candidate terms gated by a mask.
// Fixed depth: a WIN-wide AND followed by a WIN-wide OR for every mask value.
module ptalloc_sum #(
    parameter int WIN = 16
) (
    input  logic [WIN-1:0] terms,
    input  logic [WIN-1:0] mask,
    output logic           sum
);

    // Gate each candidate by its mask bit and OR the results.
    always_comb begin
        sum = |(terms & mask);
    end

endmodule

// File: rtl/ptalloc_oe.sv
`timescale 1ns/1ps
// Module: ptalloc_oe
// Per-macrocell output-enable choice. The upper half picks from terms 0/1,
// the lower half from terms 2/3. Assumes an even macrocell count.
module ptalloc_oe #(
    parameter int N_MC = 16,
    localparam int HALF = N_MC / 2
) (
    input  logic [3:0]       oe_pt,
    input  logic [N_MC-1:0]  sel,
    output logic [N_MC-1:0]  oe
);

    for (genvar i = 0; i < N_MC; i++) begin : g_oe
        localparam int PAIR = (i < HALF) ? 0 : 2;
        // Select one term of this half's pair.
        always_comb begin
            oe[i] = sel[i] ? oe_pt[PAIR+1] : oe_pt[PAIR];
        end
    end

endmodule

// File: rtl/ptalloc_block.sv
`timescale 1ns/1ps
// Module: ptalloc_block (top)
// Steers general product terms into per-macrocell sums through overlapping
// windows inside groups of macrocells, chooses output enables per half, and
// passes the block preset/clear terms through. Sum path is combinational.
module ptalloc_block #(
    parameter int N_MC = 16,
    parameter int N_PT = 80,
    parameter int WIN  = 16,
    parameter int GRP  = 4,
    localparam int AW   = $clog2(N_MC),
    localparam int NGRP = N_MC / GRP,
    localparam int TPG  = N_PT / NGRP,
    localparam int HALF = N_MC / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [WIN-1:0]    cfg_mask,
    input  logic              cfg_oe_sel,
    input  logic [N_PT-1:0]   gp_pt,
    input  logic [3:0]        oe_pt,
    input  logic [1:0]        sr_pt,
    output logic [N_MC-1:0]   mc_sum,
    output logic [N_MC-1:0]   mc_oe,
    output logic              blk_preset,
    output logic              blk_clear
);

    import ptalloc_pkg::*;

    logic [N_MC-1:0][WIN-1:0] mask_q;
    logic [N_MC-1:0]          sel_q;

    ptalloc_cfg #(.N_MC(N_MC), .WIN(WIN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .mask_in (cfg_mask),
        .sel_in  (cfg_oe_sel),
        .mask_q  (mask_q),
        .sel_q   (sel_q)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        localparam int BASE = win_base(m, GRP, TPG, WIN);
        ptalloc_sum #(.WIN(WIN)) u_sum (
            .terms (gp_pt[BASE +: WIN]),
            .mask  (mask_q[m]),
            .sum   (mc_sum[m])
        );

        // R4: an empty mask yields a constant zero
        a_r4_empty_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q[m] == '0) |-> !mc_sum[m]);

        // R10: any selected term with all terms high gives a one
        a_r10_full_terms_one: assert property (@(posedge clk) disable iff (!rst_n)
            ((&gp_pt) && (mask_q[m] != '0)) |-> mc_sum[m]);
    end

    ptalloc_oe #(.N_MC(N_MC)) u_oe (
        .oe_pt (oe_pt),
        .sel   (sel_q),
        .oe    (mc_oe)
    );

    // Block preset and clear come straight from their dedicated terms.
    always_comb begin
        blk_preset = sr_pt[0];
        blk_clear  = sr_pt[1];
    end

    // R7: the upper half is silent when its pair is low
    a_r7_upper_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_pt[1:0] == 2'b00) |-> (mc_oe[HALF-1:0] == '0));

    // R7: the lower half is silent when its pair is low
    a_r7_lower_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_pt[3:2] == 2'b00) |-> (mc_oe[N_MC-1:HALF] == '0));

endmodule

// File: tb/tb_ptalloc_block.sv
`timescale 1ns/1ps
module tb_ptalloc_block;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_mask = '0;
    logic        cfg_oe_sel = 1'b0;
    logic [79:0] gp_pt = '0;
    logic [3:0]  oe_pt = '0;
    logic [1:0]  sr_pt = '0;
    logic [15:0] mc_sum;
    logic [15:0] mc_oe;
    logic        blk_preset;
    logic        blk_clear;

    int total = 0;
    int bad = 0;

    logic [15:0] sh_mask [16];
    logic        sh_sel  [16];

    always #2.5 clk = ~clk;

    ptalloc_block dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_mask(cfg_mask), .cfg_oe_sel(cfg_oe_sel), .gp_pt(gp_pt),
        .oe_pt(oe_pt), .sr_pt(sr_pt), .mc_sum(mc_sum), .mc_oe(mc_oe),
        .blk_preset(blk_preset), .blk_clear(blk_clear)
    );

    function automatic int base_of(input int m);
        return (m / 4) * 20 + ((m % 4) * 4) / 3;
    endfunction

    function automatic logic [15:0] exp_sum();
        logic [15:0] r = '0;
        for (int m = 0; m < 16; m++)
            for (int b = 0; b < 16; b++)
                if (sh_mask[m][b] && gp_pt[base_of(m) + b]) r[m] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] exp_oe();
        logic [15:0] r;
        for (int m = 0; m < 16; m++)
            r[m] = (m < 8) ? (sh_sel[m] ? oe_pt[1] : oe_pt[0])
                           : (sh_sel[m] ? oe_pt[3] : oe_pt[2]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] mk, input logic s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_mask = mk; cfg_oe_sel = s;
        @(negedge clk);
        cfg_we = 1'b0;
        sh_mask[a] = mk; sh_sel[a] = s;
    endtask

    task automatic rand_terms();
        logic [95:0] a, b, c;
        a = {$urandom(), $urandom(), $urandom()};
        b = {$urandom(), $urandom(), $urandom()};
        c = {$urandom(), $urandom(), $urandom()};
        gp_pt = a[79:0] & b[79:0] & c[79:0];
        oe_pt = 4'($urandom());
        sr_pt = 2'($urandom());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int m = 0; m < 16; m++) begin sh_mask[m] = '0; sh_sel[m] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all terms high still gives zero sums
        gp_pt = '1; oe_pt = 4'b0101; #1;
        chk("R1 sums after reset", mc_sum, 16'h0000);
        chk("R1 enables after reset", mc_oe, 16'hFFFF);
        // R4: empty mask with all terms high
        chk("R4 empty mask", mc_sum, 16'h0000);

        // R6: term 4 shared by the whole first group
        wr(0, 16'h0010, 1'b0); wr(1, 16'h0008, 1'b0);
        wr(2, 16'h0004, 1'b0); wr(3, 16'h0001, 1'b0);
        gp_pt = '0; gp_pt[4] = 1'b1; #1;
        chk("R6 shared term", mc_sum, 16'h000F);
        // R5: window of macrocell 3 ends at term 19
        wr(3, 16'h8000, 1'b0);
        gp_pt = '0; gp_pt[19] = 1'b1; #1;
        chk("R5 last window term", mc_sum, 16'h0008);

        // R10: full mask, all terms high
        wr(9, 16'hFFFF, 1'b1);
        gp_pt = '1; #1;
        chk("R10 full mask", mc_sum, exp_sum());
        // R9: drop terms with no clock edge
        gp_pt = '0; #1;
        chk("R9 combinational drop", mc_sum, 16'h0000);

        // R7: pair crossing and half isolation
        oe_pt = 4'b1010; #1;
        chk("R7 enable select", mc_oe, exp_oe());
        oe_pt = 4'b0011; #1;
        chk("R7 lower isolated", mc_oe[15:8], 8'h00);

        // R8: preset and clear pass-through
        for (int v = 0; v < 4; v++) begin
            sr_pt = 2'(v); #1;
            chk("R8 preset/clear", {14'b0, blk_clear, blk_preset}, 16'(v));
        end

        // R3: idle port wiggling changes nothing
        rand_terms(); #1;
        begin
            logic [15:0] s0, o0;
            s0 = mc_sum; o0 = mc_oe;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                cfg_addr = 4'($urandom()); cfg_mask = 16'($urandom()); cfg_oe_sel = 1'($urandom());
            end
            @(negedge clk); #1;
            chk("R3 idle sums", mc_sum, s0);
            chk("R3 idle enables", mc_oe, o0);
        end

        // R2 R5 R7: random configurations and terms
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 2) == 0) begin
                int a;
                logic [15:0] mk;
                a = $urandom_range(0, 15);
                mk = ($urandom_range(0, 7) == 0) ? 16'h0000 : 16'($urandom());
                wr(a, mk, 1'($urandom()));
            end
            rand_terms(); #1;
            chk("R5 random sums", mc_sum, exp_sum());
            chk("R7 random enables", mc_oe, exp_oe());
        end

        // R1: reset again clears configuration
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int m = 0; m < 16; m++) begin sh_mask[m] = '0; sh_sel[m] = 1'b0; end
        gp_pt = '1; oe_pt = 4'b1010; #1;
        chk("R1 sums after second reset", mc_sum, 16'h0000);
        chk("R1 enables after second reset", mc_oe, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule